// File: doc/BRIEF.md
# Display Plane Pixel Format Expander

This block takes one raw pixel word, already fetched from memory and aligned to the right, and turns it into a common 8-bit-per-channel alpha, red, green and blue value for a display layer. A control word chooses the packed layout, and three control flags adjust it. The byte-order flag reverses the bytes inside the pixel's container. The channel-swap flag moves the alpha (or padding) field from the low end of the word to the top. The alpha-range flag decides whether an 8-bit alpha keeps its full 0..255 range or is halved to 0..128. Narrow colour and alpha fields are widened by repeating their top bits.

The datapath is one register stage controlled by a two-state machine. `ST_EMPTY` means no result is held, and `ST_FULL` means a result is presented. There are four transitions:

- LOAD: `ST_EMPTY` to `ST_FULL`, on `in_valid`.
- DRAIN: `ST_FULL` to `ST_EMPTY`, when `out_ready` is high and `in_valid` is low.
- REFILL: `ST_FULL` to `ST_FULL`, when `out_ready` and `in_valid` are both high.
- STALL: `ST_FULL` to `ST_FULL`, when `out_ready` is low.

A format code outside the supported set produces opaque black and sets a sticky error flag.

Top module: `pix_expander`

## Requirements
- R1: After reset, `out_valid` = 0, `fmt_err` = 0 and `in_ready` = 1.
- R2: 16-bit layouts, with fields given from the most significant bit down:
  - code 0: r5 g6 b5, with alpha 0xFF.
  - code 6: a1 r5 g5 b5.
  - code 7: a4 r4 g4 b4.

  A 5-bit field x becomes {x, x[4:2]} and a 6-bit field becomes {x, x[5:4]}. A 4-bit field is repeated twice, and a 1-bit alpha becomes 0x00 or 0xFF.
- R3: 24-bit and 32-bit layouts:
  - code 1: r8 g8 b8 in bits 23:0.
  - code 2: padding byte in bits 31:24, then r8 g8 b8.
  - code 4: a8 in bits 23:16, then r5 g6 b5.
  - code 5: a8 r8 g8 b8.

  The format code is ctrl[4:0].
- R4: Codes 0, 1 and 2 output alpha 0xFF, whatever the pixel bits and the padding byte hold.
- R5: For codes 4 and 5, the 8-bit alpha passes through unchanged when ctrl[5] = 1. When ctrl[5] = 0 it becomes (a+1)>>1. ctrl[5] has no effect on the other codes.
- R6: When ctrl[23] = 1, the bytes within the container are reversed before decoding. The container is 2 bytes for codes 0, 6 and 7, 3 bytes for codes 1 and 4, and 4 bytes for codes 2 and 5. Bits above the container are ignored.
- R7: When ctrl[6] = 1, the container is rotated right after any byte reversal. The rotation is by the alpha field width: 1 for code 6, 4 for code 7, 8 for codes 2, 4 and 5. It is 0 for codes 0 and 1, so ctrl[6] has no effect there.
- R8: Codes 3 and 8..31 output a=0xFF, r=g=b=0x00. Accepting such a pixel sets `fmt_err`, which stays set until reset.
- R9: An accepted pixel (`in_valid` and `in_ready`) appears with `out_valid` one clock later. `in_ready` is high when the stage is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the outputs stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Stage can accept a pixel |
| ctrl | input | 32 | Format code [4:0], alpha range [5], channel swap [6], byte order [23] |
| pix | input | 32 | Right-aligned raw pixel word |
| out_valid | output | 1 | Expanded pixel valid |
| out_ready | input | 1 | Downstream accepts the expanded pixel |
| out_a | output | 8 | Alpha |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |
| fmt_err | output | 1 | Sticky unknown-format flag |

## Verification
The hardest case to reach from the ports is a pixel waiting at the input while the stage holds an unconsumed result. The stimulus creates it by dropping `out_ready`, loading one pixel and then offering a different one. The bench confirms that the held output does not move and that the offered pixel is refused. It then releases `out_ready` so that both pixels drain on consecutive cycles. The sweep runs through all 32 codes in ascending order, so the sticky flag can be checked to be clear just before the first unknown code and set after it.

// File: rtl/pxe_pkg.sv
package pxe_pkg;
    localparam int PIX_W  = 32;
    localparam int CTRL_W = 32;
    localparam int CH_W   = 8;
    localparam int FMT_W  = 5;
    localparam int NBYTES = PIX_W / 8;
    localparam int BIT_ARANGE = 5;
    localparam int BIT_SWAP   = 6;
    localparam int BIT_BE     = 23;

    typedef enum logic [FMT_W-1:0] {
        FMT_RGB565   = 5'h00,
        FMT_RGB888   = 5'h01,
        FMT_XRGB32   = 5'h02,
        FMT_ARGB8565 = 5'h04,
        FMT_ARGB8888 = 5'h05,
        FMT_ARGB1555 = 5'h06,
        FMT_ARGB4444 = 5'h07
    } fmt_e;

    typedef enum logic { ST_EMPTY = 1'b0, ST_FULL = 1'b1 } stage_e;

    typedef struct packed {
        logic [CH_W-1:0] a;
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } px_argb_t;

    typedef struct packed {
        logic [2:0] nbytes;
        logic [3:0] aw;
    } fmt_info_t;

    function automatic fmt_info_t fmt_lookup(input logic [FMT_W-1:0] code);
        fmt_info_t f;
        f = '0;
        case (code)
            FMT_RGB565:   f = '{nbytes: 3'd2, aw: 4'd0};
            FMT_RGB888:   f = '{nbytes: 3'd3, aw: 4'd0};
            FMT_XRGB32:   f = '{nbytes: 3'd4, aw: 4'd8};
            FMT_ARGB8565: f = '{nbytes: 3'd3, aw: 4'd8};
            FMT_ARGB8888: f = '{nbytes: 3'd4, aw: 4'd8};
            FMT_ARGB1555: f = '{nbytes: 3'd2, aw: 4'd1};
            FMT_ARGB4444: f = '{nbytes: 3'd2, aw: 4'd4};
            default:      f = '0;
        endcase
        return f;
    endfunction

    function automatic logic [7:0] widen5(input logic [4:0] x);
        return {x, x[4:2]};
    endfunction

    function automatic logic [7:0] widen6(input logic [5:0] x);
        return {x, x[5:4]};
    endfunction

    function automatic logic [7:0] widen4(input logic [3:0] x);
        return {x, x};
    endfunction

    function automatic logic [7:0] scale_alpha(input logic [7:0] a, input logic full);
        logic [8:0] s;
        s = {1'b0, a} + 9'd1;
        return full ? a : s[8:1];
    endfunction
endpackage

// File: rtl/pxe_normalize.sv
module pxe_normalize
    import pxe_pkg::*;
(
    input  logic [PIX_W-1:0] pix_i,
    input  logic [2:0]       nbytes_i,
    input  logic [3:0]       aw_i,
    input  logic             be_i,
    input  logic             swap_i,
    output logic [PIX_W-1:0] norm_o
);
    logic [PIX_W-1:0] mask;
    logic [PIX_W-1:0] ordered;
    int               cw;
    int               nb;

    always_comb begin
        nb   = int'(nbytes_i);
        cw   = 8 * nb;
        mask = {PIX_W{1'b1}} >> (PIX_W - cw);
        ordered = pix_i & mask;
        if (be_i) begin
            ordered = '0;
            for (int i = 0; i < NBYTES; i++) begin
                if (i < nb) begin
                    ordered[8*i +: 8] = pix_i[8*(nb-1-i) +: 8];
                end
            end
        end
        norm_o = ordered;
        if (swap_i && (aw_i != 4'd0)) begin
            norm_o = ((ordered >> aw_i) | (ordered << (cw - int'(aw_i)))) & mask;
        end
    end
endmodule

// File: rtl/pxe_unpack.sv
module pxe_unpack
    import pxe_pkg::*;
(
    input  logic [PIX_W-1:0] norm_i,
    input  logic [FMT_W-1:0] code_i,
    input  logic             arange_i,
    output px_argb_t         px_o,
    output logic             unknown_o
);
    always_comb begin
        px_o      = '{a: 8'hFF, r: 8'h00, g: 8'h00, b: 8'h00};
        unknown_o = 1'b0;
        case (code_i)
            FMT_RGB565: begin
                px_o.r = widen5(norm_i[15:11]);
                px_o.g = widen6(norm_i[10:5]);
                px_o.b = widen5(norm_i[4:0]);
            end
            FMT_RGB888, FMT_XRGB32: begin
                px_o.r = norm_i[23:16];
                px_o.g = norm_i[15:8];
                px_o.b = norm_i[7:0];
            end
            FMT_ARGB8565: begin
                px_o.a = scale_alpha(norm_i[23:16], arange_i);
                px_o.r = widen5(norm_i[15:11]);
                px_o.g = widen6(norm_i[10:5]);
                px_o.b = widen5(norm_i[4:0]);
            end
            FMT_ARGB8888: begin
                px_o.a = scale_alpha(norm_i[31:24], arange_i);
                px_o.r = norm_i[23:16];
                px_o.g = norm_i[15:8];
                px_o.b = norm_i[7:0];
            end
            FMT_ARGB1555: begin
                px_o.a = {8{norm_i[15]}};
                px_o.r = widen5(norm_i[14:10]);
                px_o.g = widen5(norm_i[9:5]);
                px_o.b = widen5(norm_i[4:0]);
            end
            FMT_ARGB4444: begin
                px_o.a = widen4(norm_i[15:12]);
                px_o.r = widen4(norm_i[11:8]);
                px_o.g = widen4(norm_i[7:4]);
                px_o.b = widen4(norm_i[3:0]);
            end
            default: unknown_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/pix_expander.sv
module pix_expander
    import pxe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [PIX_W-1:0]  pix,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CH_W-1:0]   out_a,
    output logic [CH_W-1:0]   out_r,
    output logic [CH_W-1:0]   out_g,
    output logic [CH_W-1:0]   out_b,
    output logic              fmt_err
);
    stage_e           state_q, state_d;
    fmt_info_t        info;
    logic [PIX_W-1:0] norm;
    px_argb_t         px_d, px_q;
    logic             unknown;
    logic             load;
    logic             err_q;
    logic             ctrl_unused;

    assign ctrl_unused = ^{ctrl[CTRL_W-1:BIT_BE+1], ctrl[BIT_BE-1:BIT_SWAP+1]};
    assign info = fmt_lookup(ctrl[FMT_W-1:0]);

    pxe_normalize i_norm (
        .pix_i    (pix),
        .nbytes_i (info.nbytes),
        .aw_i     (info.aw),
        .be_i     (ctrl[BIT_BE]),
        .swap_i   (ctrl[BIT_SWAP]),
        .norm_o   (norm)
    );

    pxe_unpack i_unpack (
        .norm_i    (norm),
        .code_i    (ctrl[FMT_W-1:0]),
        .arange_i  (ctrl[BIT_ARANGE]),
        .px_o      (px_d),
        .unknown_o (unknown)
    );

    assign in_ready = (state_q == ST_EMPTY) || out_ready;
    assign load     = in_valid && in_ready;

    // next-state: LOAD, DRAIN, REFILL, STALL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px_q  <= '0;
            err_q <= 1'b0;
        end else if (load) begin
            px_q  <= px_d;
            err_q <= err_q | unknown;
        end
    end

    assign out_valid = (state_q == ST_FULL);
    assign out_a     = px_q.a;
    assign out_r     = px_q.r;
    assign out_g     = px_q.g;
    assign out_b     = px_q.b;
    assign fmt_err   = err_q;
endmodule

// File: rtl/pxe_checker.sv
module pxe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [4:0] ctrl_code,
    input logic       ctrl_arange,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_a,
    input logic [7:0] out_r,
    input logic [7:0] out_g,
    input logic [7:0] out_b,
    input logic       fmt_err
);
    assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_a) && $stable(out_r)
                                     && $stable(out_g) && $stable(out_b));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |=> fmt_err);

    assert_err_black_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fmt_err) |-> out_valid && out_a == 8'hFF && out_r == 8'h00
                           && out_g == 8'h00 && out_b == 8'h00);

    assert_opaque_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && ctrl_code == 5'h00 |=> out_a == 8'hFF);

    assert_half_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && ctrl_code == 5'h05 && !ctrl_arange |=> out_a <= 8'h80);
endmodule

bind pix_expander pxe_checker i_pxe_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .ctrl_code   (ctrl[4:0]),
    .ctrl_arange (ctrl[5]),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_a       (out_a),
    .out_r       (out_r),
    .out_g       (out_g),
    .out_b       (out_b),
    .fmt_err     (fmt_err)
);

// File: tb/test_pix_expander.sv
`timescale 1ns/1ps
module test_pix_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] ctrl = '0;
    logic [31:0] pix = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_a, out_r, out_g, out_b;
    logic        fmt_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pix_expander i_pix_expander (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .ctrl(ctrl), .pix(pix), .out_valid(out_valid), .out_ready(out_ready),
        .out_a(out_a), .out_r(out_r), .out_g(out_g), .out_b(out_b), .fmt_err(fmt_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int cont_bytes(input int code);
        case (code)
            0, 6, 7: return 2;
            1, 4:    return 3;
            2, 5:    return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int alpha_bits(input int code);
        case (code)
            2, 4, 5: return 8;
            6:       return 1;
            7:       return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int up5(input int x); return x * 8 + x / 4;  endfunction
    function automatic int up6(input int x); return x * 4 + x / 16; endfunction

    // reference: returns {a,r,g,b}
    function automatic logic [31:0] model(input logic [31:0] c, input logic [31:0] p);
        int code, nb, cw, aw, a, r, g, b;
        logic [31:0] w, n;
        code = int'(c[4:0]);
        nb = cont_bytes(code);
        if (nb == 0) return 32'hFF00_0000;
        cw = nb * 8;
        aw = alpha_bits(code);
        w = '0;
        for (int k = 0; k < nb; k++)
            w[8*k +: 8] = c[23] ? p[8*(nb-1-k) +: 8] : p[8*k +: 8];
        n = w;
        if (c[6]) for (int i = 0; i < cw; i++) n[i] = w[(i + aw) % cw];
        a = 255;
        case (code)
            0: begin r = up5(int'(n[15:11])); g = up6(int'(n[10:5])); b = up5(int'(n[4:0])); end
            1, 2: begin r = int'(n[23:16]); g = int'(n[15:8]); b = int'(n[7:0]); end
            4: begin a = int'(n[23:16]); r = up5(int'(n[15:11])); g = up6(int'(n[10:5])); b = up5(int'(n[4:0])); end
            5: begin a = int'(n[31:24]); r = int'(n[23:16]); g = int'(n[15:8]); b = int'(n[7:0]); end
            6: begin a = int'(n[15]) * 255; r = up5(int'(n[14:10])); g = up5(int'(n[9:5])); b = up5(int'(n[4:0])); end
            default: begin a = int'(n[15:12]) * 17; r = int'(n[11:8]) * 17; g = int'(n[7:4]) * 17; b = int'(n[3:0]) * 17; end
        endcase
        if ((code == 4 || code == 5) && !c[5]) a = (a + 1) / 2;
        return {8'(a), 8'(r), 8'(g), 8'(b)};
    endfunction

    function automatic logic [31:0] pattern(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h1234_5678;
            3: return 32'h80FF_0001;
            default: return 32'(k) * 32'h9E37_79B1 + 32'h0BAD_1234;
        endcase
    endfunction

    task automatic send(input logic [31:0] c, input logic [31:0] p);
        @(negedge clk);
        ctrl = c; pix = p; in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] e, e2;
        string ct, at;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid", {31'b0, out_valid}, 32'd0);
        check("R1 fmt_err",   {31'b0, fmt_err},   32'd0);
        check("R1 in_ready",  {31'b0, in_ready},  32'd1);

        for (int code = 0; code < 32; code++) begin
            if (code == 3) check("R8 err clear before unknown", {31'b0, fmt_err}, 32'd0);
            for (int mode = 0; mode < 8; mode++) begin
                for (int k = 0; k < 6; k++) begin
                    logic [31:0] c;
                    c = {8'h00, mode[2], 16'h0000, mode[1], mode[0], 5'(code)};
                    e = model(c, pattern(k));
                    send(c, pattern(k));
                    if (cont_bytes(code) == 0) ct = "R8";
                    else if (c[23]) ct = "R6";
                    else if (c[6]) ct = "R7";
                    else if (code == 0 || code >= 6) ct = "R2";
                    else ct = "R3";
                    if (code <= 2) at = "R4";
                    else if (code == 4 || code == 5) at = "R5";
                    else at = ct;
                    check($sformatf("R9 valid code %0d", code), {31'b0, out_valid}, 32'd1);
                    check($sformatf("%s rgb code %0d ctrl %h pix %h", ct, code, c, pattern(k)),
                          {8'h00, out_r, out_g, out_b}, {8'h00, e[23:0]});
                    check($sformatf("%s alpha code %0d ctrl %h pix %h", at, code, c, pattern(k)),
                          {24'h0, out_a}, {24'h0, e[31:24]});
                end
            end
            if (code == 3) check("R8 err set after unknown", {31'b0, fmt_err}, 32'd1);
        end
        check("R8 err still set", {31'b0, fmt_err}, 32'd1);

        // back-pressure: stage full, downstream stalled, second pixel waiting
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; ctrl = 32'h0000_0025; pix = 32'hC0A0_B0D0;
        e = model(32'h0000_0025, 32'hC0A0_B0D0);
        @(negedge clk);
        check("R9 full valid", {31'b0, out_valid}, 32'd1);
        check("R9 ready low when full and stalled", {31'b0, in_ready}, 32'd0);
        ctrl = 32'h0000_0007; pix = 32'h0000_F8C4;
        e2 = model(32'h0000_0007, 32'h0000_F8C4);
        repeat (3) @(negedge clk);
        check("R9 stall hold", {out_a, out_r, out_g, out_b}, e);
        check("R9 still refused", {31'b0, in_ready}, 32'd0);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 second after release", {out_a, out_r, out_g, out_b}, e2);
        check("R9 second valid", {31'b0, out_valid}, 32'd1);
        @(negedge clk);
        check("R9 drained", {31'b0, out_valid}, 32'd0);

        // streaming: one accepted pixel per clock
        for (int k = 0; k < 5; k++) begin
            ctrl = 32'h0000_0001; pix = pattern(k + 2); in_valid = 1'b1;
            @(negedge clk);
            check($sformatf("R9 stream %0d", k), {out_a, out_r, out_g, out_b},
                  model(32'h0000_0001, pattern(k + 2)));
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R9 stream end", {31'b0, out_valid}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule